// File: doc/BRIEF.md
# Pulse-Swallow Programmable Feedback Divider

This block is the digital part of a dual-modulus feedback divider for a frequency synthesizer loop. Its clock is the output of a fixed divide-by-8 prescaler that sits in front of it. One output cycle spans 32M+S input clocks, so the whole chain divides the oscillator by 8·(32M+S). Inside, a 32/33 modulus stage counts input clocks. A swallow counter holds that stage at 33 for the first S periods of each cycle. A main counter ends the cycle after M periods in total.

A controller presents a main value on `m_i`, a swallow value on `s_i` and a width selection on `mode_i`, then pulses `load_i`. The captured values sit in shadow registers and take over only when the running cycle ends. In narrow mode M is nine bits wide and its top bit is forced to zero. In wide mode M is ten bits wide. An effective M below 32 is raised to 32 and reported on `clamp_o`. Because S is at most 31, the clamped M always exceeds S. At the last input clock of each cycle, `pulse_o` is high for one clock. `mod33_o` exposes the modulus control of the 32/33 stage.

Top module: `swallow_divider`

## Requirements
- R1: While `rst_ni` is low, `pulse_o`, `mod33_o` and `clamp_o` are 0. The configuration out of reset is M=32, S=0, so the first cycles are 1024 clocks long.
- R2: Two successive `pulse_o` highs are exactly 32·M+S input clocks apart, where M and S are the active values.
- R3: `pulse_o` is high for exactly one input clock, the last clock of each cycle.
- R4: In each cycle `mod33_o` is high for exactly 33·S clocks, starting at the first clock of the cycle, and it is low in the last clock.
- R5: When `load_i` is high at a rising edge, `m_i`, `s_i` and `mode_i` are captured. They govern the cycle that starts after the current one ends, and the running cycle keeps its length.
- R6: While `load_i` is low, changes on `m_i`, `s_i` and `mode_i` have no effect on the period.
- R7: With `mode_i`=0 (narrow), bit 9 of `m_i` is ignored, so `m_i`=544 acts as M=32.
- R8: An effective M below 32 is replaced by 32. `clamp_o` goes to 1 at the load that clamped, and to 0 at a load that needed no clamp.
- R9: With `mode_i`=1 (wide), all ten bits of `m_i` are used, up to M=1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock, taken after the fixed /8 prescaler |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Strobe that captures the M, S and mode inputs |
| mode_i | input | 1 | 0: nine-bit M, 1: ten-bit M |
| m_i | input | 10 | Main counter value |
| s_i | input | 5 | Swallow counter value |
| pulse_o | output | 1 | High for one clock at the end of each division cycle |
| mod33_o | output | 1 | Modulus control; 1 selects divide-by-33 |
| clamp_o | output | 1 | The last load had M raised to the floor of 32 |

## Verification
A wrong swallow count changes both the `mod33_o` high time and the period within the first full cycle after the fault. For S up to 31 this moves the period by at most 31 clocks, so the bench measures every interval exactly, to the clock, and does not accept an approximate match. A shadow value that is adopted mid-cycle shows up as a wrong length in the cycle that carries the load. For that reason every load is placed inside a cycle whose expected length is the old one. A bad mask or clamp appears as a period that reflects the raw `m_i`, and `clamp_o` shows it one clock after the load.

// File: rtl/swallow_div_pkg.sv
package swallow_div_pkg;
  typedef enum logic {
    MODE_NARROW = 1'b0,
    MODE_WIDE   = 1'b1
  } m_mode_e;

  localparam int unsigned P_LOG_DEF    = 5;
  localparam int unsigned M_W_DEF      = 10;
  localparam int unsigned NARROW_W_DEF = 9;
  localparam int unsigned M_MIN_DEF    = 32;
endpackage

// File: rtl/sdiv_cfg_latch.sv
module sdiv_cfg_latch
  import swallow_div_pkg::*;
#(
  parameter int unsigned M_W      = M_W_DEF,
  parameter int unsigned S_W      = P_LOG_DEF,
  parameter int unsigned NARROW_W = NARROW_W_DEF,
  parameter int unsigned M_MIN    = M_MIN_DEF
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           mode_i,
  input  logic [M_W-1:0] m_i,
  input  logic [S_W-1:0] s_i,
  output logic [M_W-1:0] m_sh_o,
  output logic [S_W-1:0] s_sh_o,
  output logic           clamp_o
);
  localparam logic [M_W-1:0] M_FLOOR = M_W'(M_MIN);

  m_mode_e        mode;
  logic [M_W-1:0] m_eff;
  logic           too_small;

  assign mode = m_mode_e'(mode_i);

  // bits above the narrow width only count in wide mode
  for (genvar b = 0; b < M_W; b++) begin : g_mask
    if (b < NARROW_W) begin : g_keep
      assign m_eff[b] = m_i[b];
    end else begin : g_gate
      assign m_eff[b] = m_i[b] & (mode == MODE_WIDE);
    end
  end

  assign too_small = m_eff < M_FLOOR;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_sh_o  <= M_FLOOR;
      s_sh_o  <= '0;
      clamp_o <= 1'b0;
    end else if (load_i) begin
      m_sh_o  <= too_small ? M_FLOOR : m_eff;
      s_sh_o  <= s_i;
      clamp_o <= too_small;
    end
  end

  // R8: shadow M never below floor
  a_r8_shadow_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_sh_o >= M_FLOOR);

  // R6: shadow only moves on a load
  a_r6_shadow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(m_sh_o) && $stable(s_sh_o));
endmodule

// File: rtl/sdiv_modulus_stage.sv
module sdiv_modulus_stage
  import swallow_div_pkg::*;
#(
  parameter int unsigned P_LOG = P_LOG_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mod33_i,
  output logic period_end_o
);
  localparam int unsigned CW   = P_LOG + 1;
  localparam int unsigned PV   = 1 << P_LOG;
  localparam logic [CW-1:0] LAST_LO = CW'(PV - 1);
  localparam logic [CW-1:0] LAST_HI = CW'(PV);

  logic [CW-1:0] cnt_q;

  assign period_end_o = (cnt_q == (mod33_i ? LAST_HI : LAST_LO));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (period_end_o) cnt_q <= '0;
    else                   cnt_q <= cnt_q + CW'(1);
  end

  // R4: counter never passes the long-period terminal
  a_r4_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST_HI);
endmodule

// File: rtl/sdiv_swallow_ctr.sv
module sdiv_swallow_ctr
  import swallow_div_pkg::*;
#(
  parameter int unsigned S_W = P_LOG_DEF
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           period_end_i,
  input  logic           cycle_end_i,
  input  logic [S_W-1:0] s_sh_i,
  output logic           mod33_o
);
  logic [S_W-1:0] s_cnt_q;

  assign mod33_o = (s_cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      s_cnt_q <= '0;
    else if (cycle_end_i)             s_cnt_q <= s_sh_i;
    else if (period_end_i && mod33_o) s_cnt_q <= s_cnt_q - S_W'(1);
  end

  // R4: swallow count only climbs at a cycle boundary
  a_r4_swallow_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cycle_end_i |=> s_cnt_q <= $past(s_cnt_q));
endmodule

// File: rtl/sdiv_main_ctr.sv
module sdiv_main_ctr
  import swallow_div_pkg::*;
#(
  parameter int unsigned M_W   = M_W_DEF,
  parameter int unsigned M_MIN = M_MIN_DEF
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           period_end_i,
  input  logic [M_W-1:0] m_sh_i,
  output logic           cycle_end_o
);
  logic [M_W-1:0] m_act_q;
  logic [M_W-1:0] m_cnt_q;

  assign cycle_end_o = period_end_i && (m_cnt_q == m_act_q - M_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_act_q <= M_W'(M_MIN);
      m_cnt_q <= '0;
    end else if (cycle_end_o) begin
      m_act_q <= m_sh_i;
      m_cnt_q <= '0;
    end else if (period_end_i) begin
      m_cnt_q <= m_cnt_q + M_W'(1);
    end
  end

  // R5: active M frozen inside a cycle
  a_r5_no_midcycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cycle_end_o |=> $stable(m_act_q));

  // R2: period index stays below active M
  a_r2_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_cnt_q < m_act_q);
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import swallow_div_pkg::*;
#(
  parameter int unsigned P_LOG    = P_LOG_DEF,
  parameter int unsigned M_W      = M_W_DEF,
  parameter int unsigned NARROW_W = NARROW_W_DEF,
  parameter int unsigned M_MIN    = M_MIN_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             mode_i,
  input  logic [M_W-1:0]   m_i,
  input  logic [P_LOG-1:0] s_i,
  output logic             pulse_o,
  output logic             mod33_o,
  output logic             clamp_o
);
  localparam int unsigned S_W = P_LOG;

  logic [M_W-1:0] m_sh;
  logic [S_W-1:0] s_sh;
  logic           period_end;
  logic           cycle_end;

  sdiv_cfg_latch #(
    .M_W(M_W), .S_W(S_W), .NARROW_W(NARROW_W), .M_MIN(M_MIN)
  ) i_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .mode_i(mode_i),
    .m_i(m_i), .s_i(s_i), .m_sh_o(m_sh), .s_sh_o(s_sh), .clamp_o(clamp_o)
  );

  sdiv_modulus_stage #(.P_LOG(P_LOG)) i_mod (
    .clk_i(clk_i), .rst_ni(rst_ni), .mod33_i(mod33_o), .period_end_o(period_end)
  );

  sdiv_swallow_ctr #(.S_W(S_W)) i_swallow (
    .clk_i(clk_i), .rst_ni(rst_ni), .period_end_i(period_end),
    .cycle_end_i(cycle_end), .s_sh_i(s_sh), .mod33_o(mod33_o)
  );

  sdiv_main_ctr #(.M_W(M_W), .M_MIN(M_MIN)) i_main (
    .clk_i(clk_i), .rst_ni(rst_ni), .period_end_i(period_end),
    .m_sh_i(m_sh), .cycle_end_o(cycle_end)
  );

  assign pulse_o = cycle_end;

  // R3: single-clock pulse (cycle is always far longer than one clock)
  a_r3_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);

  // R4: last period is always the short one
  a_r4_last_short: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> !mod33_o);

  // R4: long periods only begin at a cycle start
  a_r4_rise_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mod33_o) |-> $past(pulse_o));
endmodule

// File: tb/test_swallow_divider.sv
module test_swallow_divider;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0;
  logic       mode = 1'b0;
  logic [9:0] m_in = '0;
  logic [4:0] s_in = '0;
  logic       pulse, mod33, clamp;

  int checks = 0;
  int fails = 0;
  int exp_p_q[$];
  int exp_h_q[$];
  int cur_p = 1024;
  int cur_h = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  swallow_divider i_swallow_divider (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .mode_i(mode),
    .m_i(m_in), .s_i(s_in), .pulse_o(pulse), .mod33_o(mod33), .clamp_o(clamp)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: interval and mod33 high time between pulses
  int  cnt = 0;
  int  hi = 0;
  bit  started = 1'b0;
  bit  prev_pulse = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      cnt++;
      if (mod33) hi++;
      if (pulse) begin
        check("R3 pulse width", int'(prev_pulse), 0);
        check("R4 mod33 low at cycle end", int'(mod33), 0);
        if (started) begin
          if (exp_p_q.size() == 0) begin
            check("R2 scoreboard underflow", 1, 0);
          end else begin
            check("R2 R5 R6 period", cnt, exp_p_q.pop_front());
            check("R4 mod33 high clocks", hi, exp_h_q.pop_front());
          end
        end
        started = 1'b1;
        cnt = 0;
        hi = 0;
      end
      prev_pulse = pulse;
    end
  end

  task automatic wait_pulse();
    do @(negedge clk); while (!pulse);
  endtask

  // driver: load mid-cycle, then push expected items for each later cycle
  task automatic run_cfg(input int m, input int s, input bit wide,
                         input int ncyc, input string tag);
    int meff;
    bit exp_clamp;
    meff = wide ? m : (m % 512);
    exp_clamp = (meff < 32);
    if (exp_clamp) meff = 32;
    wait_pulse();
    exp_p_q.push_back(cur_p);
    exp_h_q.push_back(cur_h);
    @(negedge clk);
    m_in = 10'(m); s_in = 5'(s); mode = wide; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    check({tag, " R8 clamp flag"}, int'(clamp), int'(exp_clamp));
    // R6: scramble inputs without a load
    m_in = ~m_in; s_in = ~s_in; mode = ~mode;
    cur_p = 32 * meff + s;
    cur_h = 33 * s;
    for (int i = 0; i < ncyc; i++) begin
      wait_pulse();
      exp_p_q.push_back(cur_p);
      exp_h_q.push_back(cur_h);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset pulse", int'(pulse), 0);
    check("R1 reset mod33", int'(mod33), 0);
    check("R1 reset clamp", int'(clamp), 0);
    rst_n = 1'b1;
    run_cfg(100, 7, 1'b1, 2, "R2 R5");        // first interval checks R1 reset config
    run_cfg(544, 5, 1'b0, 2, "R7");           // narrow: acts as M=32
    run_cfg(544, 3, 1'b1, 1, "R9");           // wide: M=544
    run_cfg(5, 31, 1'b1, 2, "R8 low");        // clamped to 32
    run_cfg(33, 31, 1'b1, 2, "R8 clear");
    run_cfg(1023, 31, 1'b1, 1, "R9 max");
    run_cfg(511, 31, 1'b0, 1, "R7 max");
    wait_pulse();
    @(negedge clk);
    check("R2 scoreboard drained", exp_p_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule